// File: doc/BRIEF.md
# SMBus Alert-Response Slave Responder

This block is the alert side of an SMBus slave. When a local fault event arrives it latches a pending alert and pulls the shared, open-drain alert line low. The host finds out which device raised the alert by reading from the shared alert-response address, 0001100, which every alerting slave accepts at once. In the single data byte of that read, each alerting slave sends its own 7-bit address followed by a 1. The data line is a wired-AND, so a 0 beats a 1 and the lowest address comes through intact.

The block checks every bit it releases against the bus level it samples. When it sends a 1 and sees a 0, it stops driving for the rest of the byte. A slave that loses this way keeps its alert asserted, so the host must treat the alert as a level and read again. The block releases its alert only after it has sent its whole address byte without losing. At that point it also pulses a one-cycle serviced flag.

The raw SCL and SDA levels come in through two-flop synchronizers and are sampled on the system clock. The drive outputs are enables for external open-drain pads. A 1 on an enable pulls the pin low.

Top module: `smb_alert_responder`

## Requirements
- R1: A one-cycle high on `fault_evt` sets `alert_drive` to 1 on the next clock. It stays 1 until the alert is serviced. A fault in the same cycle as servicing keeps it at 1.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Either one in the middle of a transfer sends the block back to waiting for a new START, and a pending alert stays pending.
- R3: The block acknowledges, by pulling SDA low on the ninth clock, only when three things hold: the address is 0001100, the R/W bit is 1 (read), and an alert is pending. A write, any other address, or no pending alert gets no acknowledge.
- R4: The data byte of a won read is {own_addr[6:0], 1}, sent MSB first. `sda_drive` only ever rises while the synchronized SCL is low.
- R5: When the bench's competing slave has a lower address, the host reads the competitor's byte. When the competitor's address is higher or equal, the host reads this block's byte.
- R6: After losing arbitration, the block releases SDA for the rest of the byte. It does not pulse `serviced`, and `alert_drive` stays 1.
- R7: After a byte sent without loss, the ninth clock (or a STOP in its place) clears `alert_drive` and pulses `serviced` high for exactly one cycle.
- R8: After reset, `sda_drive`, `alert_drive` and `serviced` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level (wired-AND bus) |
| fault_evt | input | 1 | Local fault event, one cycle per event |
| own_addr | input | 7 | This slave's 7-bit address |
| sda_drive | output | 1 | 1 pulls SDA low |
| alert_drive | output | 1 | 1 pulls the alert line low |
| serviced | output | 1 | One-cycle pulse when the alert is released |

## Verification
The hardest situation to reach is a loss partway through the address byte. It needs a second slave on the wired-AND line that acknowledges the same read and whose address first differs from this block's at a chosen bit.

The bench models that competitor. It drives its own address bits, drops out itself when it loses, and ANDs its drive into the SDA line the block sees. Stimulus mixes directed lower and higher competitor addresses with random pairs, so the first differing bit lands at many positions.

A START part way through the address and a STOP part way through the address are both driven directly to show the pending alert survives.

// File: rtl/sma_pkg.sv
`timescale 1ns/1ps
package sma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } sma_state_e;
endpackage

// File: rtl/sma_sync.sv
`timescale 1ns/1ps
module sma_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sma_cond.sv
`timescale 1ns/1ps
module sma_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign sda_lvl   = sda;
endmodule

// File: rtl/sma_alert.sv
`timescale 1ns/1ps
module sma_alert (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)        pending <= 1'b0;
    else if (fault) pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end
endmodule

// File: rtl/sma_xfer.sv
`timescale 1ns/1ps
module sma_xfer
  import sma_pkg::*;
#(
  parameter int            AW        = 7,
  parameter logic [AW-1:0] RESP_ADDR = AW'(7'h0C)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_lvl,
  input  logic          pending,
  input  logic [AW-1:0] own_addr,
  output logic          drv,
  output logic          win
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);

  sma_state_e    st;
  logic [CW-1:0] cnt;
  logic [BW-2:0] shreg;
  logic [BW-1:0] txb;
  logic [BW-1:0] rx_byte;

  assign rx_byte = {shreg, sda_lvl};
  assign win     = (st == ST_MACK) && (scl_rise || stop_det) && !start_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      txb   <= '0;
      drv   <= 1'b0;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
      drv <= 1'b0;
    end else if (stop_det) begin
      st  <= ST_IDLE;
      drv <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          shreg <= rx_byte[BW-2:0];
          if (cnt == CW'(BW-1)) begin
            cnt <= '0;
            if (rx_byte == {RESP_ADDR, 1'b1} && pending) begin
              st  <= ST_ACK_WAIT;
              txb <= {own_addr, 1'b1};
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          drv <= 1'b1;
          st  <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          drv <= ~txb[BW-1];
          txb <= {txb[BW-2:0], 1'b0};
          st  <= ST_TX;
        end
        ST_TX: begin
          if (scl_rise) begin
            if (!drv && !sda_lvl) begin
              st <= ST_HOLD;
            end else if (cnt == CW'(BW-1)) begin
              cnt <= '0;
              st  <= ST_MACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (scl_fall) begin
            drv <= ~txb[BW-1];
            txb <= {txb[BW-2:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_fall) drv <= 1'b0;
          if (scl_rise) st  <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_alert_responder.sv
`timescale 1ns/1ps
module smb_alert_responder #(
  parameter int             AW          = 7,
  parameter int             SYNC_STAGES = 2,
  parameter logic [AW-1:0]  RESP_ADDR   = AW'(7'h0C)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          fault_evt,
  input  logic [AW-1:0] own_addr,
  output logic          sda_drive,
  output logic          alert_drive,
  output logic          serviced
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, syn_lines;
  logic scl_syn, sda_syn;
  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic pending, win;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    sma_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_lines[g]),
      .q   (syn_lines[g])
    );
  end

  assign scl_syn = syn_lines[0];
  assign sda_syn = syn_lines[1];

  sma_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl_syn),
    .sda       (sda_syn),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  sma_alert u_alert (
    .clk     (clk),
    .rst     (rst),
    .fault   (fault_evt),
    .clear   (win),
    .pending (pending)
  );

  sma_xfer #(.AW(AW), .RESP_ADDR(RESP_ADDR)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .pending   (pending),
    .own_addr  (own_addr),
    .drv       (sda_drive),
    .win       (win)
  );

  assign alert_drive = pending;

  always_ff @(posedge clk) begin
    if (rst) serviced <= 1'b0;
    else     serviced <= win;
  end
endmodule

// File: rtl/sma_checker.sv
`timescale 1ns/1ps
module sma_checker (
  input logic clk,
  input logic rst,
  input logic fault_evt,
  input logic sda_drive,
  input logic alert_drive,
  input logic serviced,
  input logic scl_s
);
  // R1: a fault raises the alert drive on the next cycle
  p_fault_sets_alert_r1: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> alert_drive);

  // R4: the data line is only newly pulled low while SCL is low
  p_drive_on_low_scl_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive) |-> !scl_s);

  // R3: the block never starts pulling SDA unless its alert is pending
  p_drive_needs_alert_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive) |-> alert_drive);

  // R7: the alert is released only together with the serviced pulse
  p_release_with_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_drive) |-> serviced);

  // R7: the serviced pulse lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    serviced |=> !serviced);

  // R7: the serviced pulse leaves the alert released unless a fault arrived
  p_pulse_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (serviced && !$past(fault_evt)) |-> !alert_drive);
endmodule

bind smb_alert_responder sma_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .fault_evt   (fault_evt),
  .sda_drive   (sda_drive),
  .alert_drive (alert_drive),
  .serviced    (serviced),
  .scl_s       (scl_syn)
);

// File: tb/smb_alert_responder_tb.sv
`timescale 1ns/1ps
module smb_alert_responder_tb;
  localparam int HALF = 10;
  localparam logic [6:0] RESP = 7'h0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1, host_sda = 1'b1, comp_drv = 1'b0;
  logic fault_evt = 1'b0;
  logic [6:0] own_addr = 7'h35;
  logic sda_drive, alert_drive, serviced;
  logic sda_line;
  logic drv_end;
  int   n_chk = 0, n_fail = 0, svc_cnt = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  assign sda_line = host_sda & ~sda_drive & ~comp_drv;

  smb_alert_responder u_dut (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_line),
    .fault_evt(fault_evt), .own_addr(own_addr),
    .sda_drive(sda_drive), .alert_drive(alert_drive), .serviced(serviced)
  );

  always @(posedge clk) if (serviced) svc_cnt <= svc_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(bit pend, bit c_on, logic [6:0] own, logic [6:0] comp);
    if (pend && c_on) return (own <= comp) ? {own, 1'b1} : {comp, 1'b1};
    if (pend) return {own, 1'b1};
    return {comp, 1'b1};
  endfunction

  task automatic half();
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start();
    host_sda = 1'b1; host_scl = 1'b1; half();
    host_sda = 1'b0; half();
    host_scl = 1'b0; half();
  endtask

  task automatic do_stop();
    host_sda = 1'b0; half();
    host_scl = 1'b1; half();
    host_sda = 1'b1; half();
  endtask

  task automatic bit_xfer(input logic hb, input logic c_en, input logic cb, output logic smp);
    host_sda = hb;
    comp_drv = c_en & ~cb;
    half();
    host_scl = 1'b1;
    half();
    smp = sda_line;
    half();
    host_scl = 1'b0;
    half();
  endtask

  task automatic pulse_fault();
    @(negedge clk); fault_evt = 1'b1;
    @(negedge clk); fault_evt = 1'b0;
  endtask

  task automatic xact(input logic [6:0] a, input logic rw, input bit c_on,
                      input logic [6:0] c_addr, output logic acked, output logic [7:0] rd);
    logic s;
    bit   c_ack, cact;
    logic [7:0] cb;
    do_start();
    for (int i = 0; i < 7; i++) bit_xfer(a[6-i], 1'b0, 1'b0, s);
    bit_xfer(rw, 1'b0, 1'b0, s);
    c_ack = c_on && (a == RESP) && rw;
    bit_xfer(1'b1, c_ack, 1'b0, s);
    acked = !s;
    rd = '0;
    if (acked && rw) begin
      cact = c_ack;
      cb = {c_addr, 1'b1};
      for (int i = 0; i < 8; i++) begin
        bit_xfer(1'b1, cact, cb[7-i], s);
        rd[7-i] = s;
        if (cact && cb[7-i] && !s) cact = 0;
      end
      drv_end = sda_drive;
      bit_xfer(1'b1, 1'b0, 1'b0, s);
    end
    comp_drv = 1'b0;
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    logic s;
    int sv0;
    bit pend;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 sda_drive", sda_drive, 0);
    chk("R8 alert_drive", alert_drive, 0);
    chk("R8 serviced", serviced, 0);

    // R3 no pending alert: no ack
    xact(RESP, 1'b1, 0, 7'h00, ack, rd);
    chk("R3 no pending ack", ack, 0);

    // R1 fault raises alert next cycle
    @(negedge clk); fault_evt = 1'b1;
    @(negedge clk); fault_evt = 1'b0;
    chk("R1 alert set", alert_drive, 1);
    repeat (20) @(negedge clk);
    chk("R1 alert held", alert_drive, 1);

    // R3 write to alert address, other address
    xact(RESP, 1'b0, 0, 7'h00, ack, rd);
    chk("R3 write no ack", ack, 0);
    xact(7'h2A, 1'b1, 0, 7'h00, ack, rd);
    chk("R3 other addr no ack", ack, 0);
    chk("R3 alert kept", alert_drive, 1);

    // R2 STOP mid address
    do_start();
    for (int i = 0; i < 3; i++) bit_xfer(RESP[6-i], 1'b0, 1'b0, s);
    do_stop();
    chk("R2 stop keeps alert", alert_drive, 1);
    chk("R2 stop releases sda", sda_drive, 0);

    // R2 START mid address, then full won read via repeated start
    do_start();
    for (int i = 0; i < 4; i++) bit_xfer(RESP[6-i], 1'b0, 1'b0, s);
    chk("R2 restart keeps alert", alert_drive, 1);
    sv0 = svc_cnt;
    xact(RESP, 1'b1, 0, 7'h00, ack, rd);
    chk("R3 ack pending", ack, 1);
    chk("R4 data byte", rd, {7'h35, 1'b1});
    chk("R7 serviced once", svc_cnt - sv0, 1);
    chk("R7 alert released", alert_drive, 0);

    // R5/R6 lower competitor wins
    pulse_fault();
    sv0 = svc_cnt;
    xact(RESP, 1'b1, 1, 7'h10, ack, rd);
    chk("R5 lower comp byte", rd, {7'h10, 1'b1});
    chk("R6 loser released sda", drv_end, 0);
    chk("R6 no serviced", svc_cnt - sv0, 0);
    chk("R6 alert kept", alert_drive, 1);

    // R5/R7 higher competitor loses
    sv0 = svc_cnt;
    xact(RESP, 1'b1, 1, 7'h50, ack, rd);
    chk("R5 own byte wins", rd, {7'h35, 1'b1});
    chk("R7 serviced after win", svc_cnt - sv0, 1);
    chk("R7 alert cleared", alert_drive, 0);

    // random mix
    pend = 0;
    for (int it = 0; it < 40; it++) begin
      int kind;
      bit c_on;
      logic [6:0] comp, a;
      logic rw, exp_ack;
      own_addr = 7'($urandom);
      comp = 7'($urandom);
      if ($urandom % 2) begin pulse_fault(); pend = 1; end
      kind = $urandom % 4;
      c_on = (kind < 2) && ($urandom % 2);
      a  = (kind == 3) ? ((7'($urandom) == RESP) ? 7'h01 : 7'h33) : RESP;
      rw = (kind == 2) ? 1'b0 : 1'b1;
      exp_ack = (a == RESP) && rw && (pend || c_on);
      sv0 = svc_cnt;
      xact(a, rw, c_on, comp, ack, rd);
      chk("R3 rand ack", ack, exp_ack);
      if (exp_ack) chk("R5 rand data", rd, exp_data(pend, c_on, own_addr, comp));
      if (exp_ack && pend && (!c_on || own_addr <= comp)) begin
        chk("R7 rand serviced", svc_cnt - sv0, 1);
        pend = 0;
      end else begin
        chk("R6 rand no serviced", svc_cnt - sv0, 0);
      end
      chk("R1 rand alert", alert_drive, pend);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule